// File: doc/BRIEF.md
# Integer Operate Execution Unit

This block is the integer execute stage of a 64-bit processor pipeline. Each cycle it may accept one 32-bit integer-operate instruction word together with the two values read from the register file. It picks the second operand, either the register value or an 8-bit literal taken from the instruction word. It then runs one of the supported operations and presents, one clock later, the result, the destination index and a write enable for the register file.

The supported operations are quadword and longword add and subtract, the same with the second operand pre-scaled by 4 or 8, and signed and unsigned compares that produce 0 or 1. It also covers the six bitwise logic functions, conditional moves that test the first operand against zero, and left, right and arithmetic-right shifts. There are no flags: an add that overflows keeps its low bits. An instruction the block does not recognise raises an illegal-instruction output instead of writing.

Top module: `intop_exec`

## Requirements
- R1: Instruction bit 12 picks the second operand. When it is 0, the operand is the register value named by bits 20:16. When it is 1, bits 20:13 form an 8-bit literal, zero-extended to 64 bits, that takes its place. Opcode sits in bits 31:26, the first source index in 25:21, the 7-bit function code in 11:5 and the destination index in 4:0.
- R2: A source field equal to 31 supplies zero, whatever value arrives on the matching read port.
- R3: A destination field equal to 31 never produces a write enable.
- R4: Under opcode 0x10, function 0x08 adds and 0x09 subtracts as quadwords. The result wraps modulo 2^64.
- R5: Under opcode 0x10, functions 0x00 (add) and 0x01 (subtract) work on longwords. The upper 32 bits of both sources are ignored, and the 32-bit result is sign-extended to 64 bits.
- R6: Under opcode 0x10, the scaled forms shift the second operand left before the add or subtract. Function bit 0 selects subtract, bits 2:1 select the shift (01 gives 2, 10 gives 3), and bit 3 selects quadword over longword. This gives 0x02-0x05 and 0x0A-0x0D. Function codes 0x06, 0x07, 0x0E and 0x0F are illegal.
- R7: Under opcode 0x10, functions 0x10 (equal), 0x11 (signed less), 0x12 (signed less-or-equal), 0x13 (unsigned less) and 0x14 (unsigned less-or-equal) write 1 when the relation of first to second operand holds and 0 otherwise.
- R8: Under opcode 0x11, functions 0x00 to 0x05 are AND, NAND, OR, NOR, XOR and XNOR of the two operands.
- R9: Under opcode 0x11, functions 0x10 to 0x15 are conditional moves. Each tests the first operand as a signed 64-bit value against zero: equal, not equal, less, less-or-equal, greater-or-equal and greater, in that order. It writes the second operand only when the test passes, and otherwise raises no write enable.
- R10: Under opcode 0x12, functions 0x00, 0x01 and 0x02 are logical left, logical right and arithmetic right shifts of the first operand. The amount is the low 6 bits of the second operand.
- R11: Any other opcode or function code raises `illegal` and no write enable.
- R12: Outputs appear on the clock edge that samples `issue_valid` high, and `wr_idx` equals the destination field. A cycle without `issue_valid` gives no write enable and no `illegal` on the next edge. Reset clears `wr_en`, `illegal`, `wr_idx` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| issue_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 32 | Instruction word |
| ra_val | input | 64 | Register value read for the first source field |
| rb_val | input | 64 | Register value read for the second source field |
| wr_en | output | 1 | Write the result to the register file |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Result value |
| illegal | output | 1 | Instruction not recognised |

## Verification
Every legal function code runs against every pair from eight operand values. The values are zero, one, all ones, the most negative and most positive quadword, a pattern with only the low half set, a mixed pattern, and a sign-extended negative longword. This separates signed from unsigned compares, quadword from longword results and carry into bit 32. Every literal value and every shift amount, including register amounts of 64 and above, are swept to expose literal zero-extension and the 6-bit amount mask. Register 31 in each source and destination field, conditional moves that fail, and the whole space of unused opcodes and function codes show the cases that must not write.

// File: rtl/intop_pkg.sv
package intop_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int LIT_W     = 8;
  localparam int OPC_W     = 6;
  localparam int FN_W      = 7;

  localparam logic [OPC_W-1:0] OPC_ARITH = 6'h10;
  localparam logic [OPC_W-1:0] OPC_LOGIC = 6'h11;
  localparam logic [OPC_W-1:0] OPC_SHIFT = 6'h12;

  typedef enum logic [2:0] {U_NONE, U_ADD, U_CMP, U_BIT, U_CMOV, U_SHF} unit_e;
  typedef enum logic [2:0] {CC_EQ, CC_NE, CC_LT, CC_LE, CC_GE, CC_GT, CC_ULT, CC_ULE} cond_e;
  typedef enum logic [2:0] {LG_AND, LG_NAND, LG_OR, LG_NOR, LG_XOR, LG_XNOR} bitop_e;
  typedef enum logic [1:0] {SH_LL, SH_RL, SH_RA} shf_e;

  typedef struct packed {
    logic       legal;
    unit_e      unit;
    logic       quad;
    logic       sub;
    logic [1:0] scale;
    cond_e      cond;
    bitop_e     bop;
    shf_e       sop;
  } ctrl_t;
endpackage

// File: rtl/intop_decode.sv
module intop_decode
  import intop_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl.legal = 1'b0;
    ctrl.unit  = U_NONE;
    ctrl.quad  = 1'b0;
    ctrl.sub   = 1'b0;
    ctrl.scale = 2'd0;
    ctrl.cond  = CC_EQ;
    ctrl.bop   = LG_AND;
    ctrl.sop   = SH_LL;
    unique case (opc)
      OPC_ARITH: begin
        if (fn[6:4] == 3'b000 && fn[2:1] != 2'b11) begin
          ctrl.legal = 1'b1;
          ctrl.unit  = U_ADD;
          ctrl.quad  = fn[3];
          ctrl.sub   = fn[0];
          ctrl.scale = fn[2:1];
        end else if (fn[6:3] == 4'b0010 && fn[2:0] <= 3'd4) begin
          ctrl.legal = 1'b1;
          ctrl.unit  = U_CMP;
          case (fn[2:0])
            3'd0:    ctrl.cond = CC_EQ;
            3'd1:    ctrl.cond = CC_LT;
            3'd2:    ctrl.cond = CC_LE;
            3'd3:    ctrl.cond = CC_ULT;
            default: ctrl.cond = CC_ULE;
          endcase
        end
      end
      OPC_LOGIC: begin
        if (fn[6:3] == 4'b0000 && fn[2:0] <= 3'd5) begin
          ctrl.legal = 1'b1;
          ctrl.unit  = U_BIT;
          ctrl.bop   = bitop_e'(fn[2:0]);
        end else if (fn[6:3] == 4'b0010 && fn[2:0] <= 3'd5) begin
          ctrl.legal = 1'b1;
          ctrl.unit  = U_CMOV;
          ctrl.cond  = cond_e'(fn[2:0]);
        end
      end
      OPC_SHIFT: begin
        if (fn <= 7'd2) begin
          ctrl.legal = 1'b1;
          ctrl.unit  = U_SHF;
          ctrl.sop   = shf_e'(fn[1:0]);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/intop_operand.sv
module intop_operand #(
  parameter int DATA_W    = 64,
  parameter int REG_IDX_W = 5,
  parameter int LIT_W     = 8
) (
  input  logic [REG_IDX_W-1:0] ra_idx,
  input  logic [REG_IDX_W-1:0] rb_idx,
  input  logic                 lit_sel,
  input  logic [LIT_W-1:0]     lit,
  input  logic [DATA_W-1:0]    ra_val,
  input  logic [DATA_W-1:0]    rb_val,
  output logic [DATA_W-1:0]    opa,
  output logic [DATA_W-1:0]    opb
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '1;
  localparam int PAD_W = DATA_W - LIT_W;

  always_comb begin
    opa = (ra_idx == ZERO_IDX) ? '0 : ra_val;
    if (lit_sel)
      opb = {{PAD_W{1'b0}}, lit};
    else
      opb = (rb_idx == ZERO_IDX) ? '0 : rb_val;
  end
endmodule

// File: rtl/intop_alu.sv
module intop_alu
  import intop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              take
);
  localparam int HALF    = DATA_W / 2;
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]  sb, sum, bres, sres;
  logic [SHAMT_W-1:0] shamt;
  logic eq, slt, ult, a_zero, a_neg, cmp_ok, mov_ok;

  always_comb begin
    case (ctrl.scale)
      2'd1:    sb = opb << 2;
      2'd2:    sb = opb << 3;
      default: sb = opb;
    endcase
    sum = ctrl.sub ? (opa - sb) : (opa + sb);

    eq     = (opa == opb);
    slt    = ($signed(opa) < $signed(opb));
    ult    = (opa < opb);
    a_zero = (opa == '0);
    a_neg  = opa[DATA_W-1];

    case (ctrl.cond)
      CC_EQ:   cmp_ok = eq;
      CC_LT:   cmp_ok = slt;
      CC_LE:   cmp_ok = slt | eq;
      CC_ULT:  cmp_ok = ult;
      CC_ULE:  cmp_ok = ult | eq;
      default: cmp_ok = 1'b0;
    endcase
    case (ctrl.cond)
      CC_EQ:   mov_ok = a_zero;
      CC_NE:   mov_ok = ~a_zero;
      CC_LT:   mov_ok = a_neg;
      CC_LE:   mov_ok = a_neg | a_zero;
      CC_GE:   mov_ok = ~a_neg;
      CC_GT:   mov_ok = ~a_neg & ~a_zero;
      default: mov_ok = 1'b0;
    endcase

    case (ctrl.bop)
      LG_AND:  bres = opa & opb;
      LG_NAND: bres = ~(opa & opb);
      LG_OR:   bres = opa | opb;
      LG_NOR:  bres = ~(opa | opb);
      LG_XOR:  bres = opa ^ opb;
      default: bres = ~(opa ^ opb);
    endcase

    shamt = opb[SHAMT_W-1:0];
    case (ctrl.sop)
      SH_LL:   sres = opa << shamt;
      SH_RL:   sres = opa >> shamt;
      default: sres = $unsigned($signed(opa) >>> shamt);
    endcase

    take = ctrl.legal;
    case (ctrl.unit)
      U_ADD:   result = ctrl.quad ? sum : {{HALF{sum[HALF-1]}}, sum[HALF-1:0]};
      U_CMP:   result = {{(DATA_W-1){1'b0}}, cmp_ok};
      U_BIT:   result = bres;
      U_CMOV: begin
        result = opb;
        take   = ctrl.legal & mov_ok;
      end
      U_SHF:   result = sres;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/intop_exec.sv
module intop_exec
  import intop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  input  logic [INSN_W-1:0]    insn,
  input  logic [DATA_W-1:0]    ra_val,
  input  logic [DATA_W-1:0]    rb_val,
  output logic                 wr_en,
  output logic [REG_IDX_W-1:0] wr_idx,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 illegal
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '1;

  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  ctrl_t             ctrl;
  logic [DATA_W-1:0] opa, opb, result;
  logic              take;
  logic [REG_IDX_W-1:0] rc;

  assign rc = insn[4:0];

  intop_decode u_dec (
    .opc  (insn[31:26]),
    .fn   (insn[11:5]),
    .ctrl (ctrl)
  );

  intop_operand #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W), .LIT_W(LIT_W)) u_opnd (
    .ra_idx  (insn[25:21]),
    .rb_idx  (insn[20:16]),
    .lit_sel (insn[12]),
    .lit     (insn[20:13]),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .opa     (opa),
    .opb     (opb)
  );

  intop_alu #(.DATA_W(DATA_W)) u_alu (
    .ctrl   (ctrl),
    .opa    (opa),
    .opb    (opb),
    .result (result),
    .take   (take)
  );

  logic wr_en_d, illegal_d;
  always_comb begin
    wr_en_d   = issue_valid & take & (rc != ZERO_IDX);
    illegal_d = issue_valid & ~ctrl.legal;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_en   <= 1'b0;
      illegal <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= wr_en_d;
      illegal <= illegal_d;
      if (issue_valid) begin
        wr_idx  <= rc;
        wr_data <= result;
      end
    end
  end
endmodule

// File: rtl/intop_exec_chk.sv
module intop_exec_chk
  import intop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 issue_valid,
  input logic [INSN_W-1:0]    insn,
  input logic                 wr_en,
  input logic [REG_IDX_W-1:0] wr_idx,
  input logic [DATA_W-1:0]    wr_data,
  input logic                 illegal
);
  localparam int HALF = DATA_W / 2;

  AST_ZERO_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != 5'd31)); // R3

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (!wr_en && !illegal)); // R12

  AST_DEST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (wr_idx == $past(insn[4:0]))); // R12

  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && insn[31:26] == OPC_ARITH && insn[11:8] == 4'b0010 && insn[7:5] <= 3'd4)
    |=> (wr_data[DATA_W-1:1] == '0)); // R7

  AST_LONG_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && insn[31:26] == OPC_ARITH && insn[11:8] == 4'b0000 && insn[7:6] != 2'b11)
    |=> (wr_data[DATA_W-1:HALF] == {HALF{wr_data[HALF-1]}})); // R5
endmodule

bind intop_exec intop_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .issue_valid (issue_valid),
  .insn        (insn),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .illegal     (illegal)
);

// File: tb/tb_intop_exec.sv
`timescale 1ns/1ps
module tb_intop_exec;
  logic        clk, rst_n, issue_valid;
  logic [31:0] insn;
  logic [63:0] ra_val, rb_val;
  logic        wr_en, illegal;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  intop_exec dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .insn(insn),
    .ra_val(ra_val), .rb_val(rb_val), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mkr(input logic [5:0] op, input logic [4:0] ra,
                                      input logic [4:0] rb, input logic [6:0] fn,
                                      input logic [4:0] rc);
    return {op, ra, rb, 3'b000, 1'b0, fn, rc};
  endfunction

  function automatic logic [31:0] mkl(input logic [5:0] op, input logic [4:0] ra,
                                      input logic [7:0] lit, input logic [6:0] fn,
                                      input logic [4:0] rc);
    return {op, ra, lit, 1'b1, fn, rc};
  endfunction

  function automatic logic [63:0] pat(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h7FFF_FFFF_FFFF_FFFF;
      5: return 64'h0000_0000_FFFF_FFFF;
      6: return 64'h1234_5678_9ABC_DEF0;
      default: return 64'hFFFF_FFFF_8000_0000;
    endcase
  endfunction

  // expected {illegal, wr_en, data} from the requirement text
  function automatic logic [65:0] model(input logic [31:0] ins, input logic [63:0] av,
                                        input logic [63:0] bv);
    logic [63:0] a, b, sb, d;
    logic [31:0] t;
    logic [5:0]  op;
    logic [6:0]  f;
    logic ill, keep;
    a = (ins[25:21] == 5'd31) ? 64'h0 : av;
    if (ins[12]) b = {56'h0, ins[20:13]};
    else         b = (ins[20:16] == 5'd31) ? 64'h0 : bv;
    op = ins[31:26]; f = ins[11:5];
    ill = 1'b1; keep = 1'b1; d = 64'h0;
    if (op == 6'h10) begin
      if (f[6:4] == 3'd0 && f[2:1] != 2'd3) begin
        ill = 1'b0;
        if (f[2:1] == 2'd1)      sb = b * 64'd4;
        else if (f[2:1] == 2'd2) sb = b * 64'd8;
        else                     sb = b;
        if (f[3]) d = f[0] ? a - sb : a + sb;
        else begin
          t = f[0] ? a[31:0] - sb[31:0] : a[31:0] + sb[31:0];
          d = {{32{t[31]}}, t};
        end
      end else if (f >= 7'h10 && f <= 7'h14) begin
        ill = 1'b0;
        case (f)
          7'h10: d = {63'h0, a == b};
          7'h11: d = {63'h0, $signed(a) < $signed(b)};
          7'h12: d = {63'h0, $signed(a) <= $signed(b)};
          7'h13: d = {63'h0, a < b};
          default: d = {63'h0, a <= b};
        endcase
      end
    end else if (op == 6'h11) begin
      if (f <= 7'h05) begin
        ill = 1'b0;
        case (f)
          7'h00: d = a & b;
          7'h01: d = ~(a & b);
          7'h02: d = a | b;
          7'h03: d = ~(a | b);
          7'h04: d = a ^ b;
          default: d = ~(a ^ b);
        endcase
      end else if (f >= 7'h10 && f <= 7'h15) begin
        ill = 1'b0; d = b;
        case (f)
          7'h10: keep = ($signed(a) == 0);
          7'h11: keep = ($signed(a) != 0);
          7'h12: keep = ($signed(a) < 0);
          7'h13: keep = ($signed(a) <= 0);
          7'h14: keep = ($signed(a) >= 0);
          default: keep = ($signed(a) > 0);
        endcase
      end
    end else if (op == 6'h12) begin
      if (f <= 7'h02) begin
        ill = 1'b0;
        case (f)
          7'h00: d = a << b[5:0];
          7'h01: d = a >> b[5:0];
          default: d = $unsigned($signed(a) >>> b[5:0]);
        endcase
      end
    end
    return {ill, (!ill && keep && ins[4:0] != 5'd31), d};
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    logic [6:0] f;
    f = ins[11:5];
    if (ins[31:26] == 6'h10) begin
      if (f >= 7'h10) return "R7";
      if (f[2:1] != 2'd0) return "R6";
      return f[3] ? "R4" : "R5";
    end
    if (ins[31:26] == 6'h11) return (f < 7'h08) ? "R8" : "R9";
    return "R10";
  endfunction

  task automatic run(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                     input string tag);
    logic [65:0] e;
    @(negedge clk);
    insn = ins; ra_val = a; rb_val = b; issue_valid = 1'b1;
    e = model(ins, a, b);
    @(posedge clk);
    #1;
    nchk++;
    if (illegal !== e[65] || wr_en !== e[64] ||
        (e[64] && (wr_data !== e[63:0] || wr_idx !== ins[4:0]))) begin
      nerr++;
      $display("FAIL %s insn=%h a=%h b=%h: got ill=%b we=%b idx=%0d data=%h, exp ill=%b we=%b idx=%0d data=%h",
               tag, ins, a, b, illegal, wr_en, wr_idx, wr_data, e[65], e[64], ins[4:0], e[63:0]);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got no end of run, exp completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; insn = '0; ra_val = '0; rb_val = '0;
    repeat (3) @(posedge clk);
    #1;
    nchk++;
    if (wr_en !== 1'b0 || illegal !== 1'b0 || wr_data !== 64'h0 || wr_idx !== 5'd0) begin
      nerr++;
      $display("FAIL R12 reset: got we=%b ill=%b idx=%0d data=%h, exp all zero",
               wr_en, illegal, wr_idx, wr_data);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // all legal functions against all operand pairs
    for (int fi = 0; fi < 32; fi++) begin
      logic [5:0] op; logic [6:0] fn;
      if (fi < 12)      begin op = 6'h10; fn = (fi < 6) ? 7'(fi) : 7'(fi + 2); end
      else if (fi < 17) begin op = 6'h10; fn = 7'(fi - 12 + 16); end
      else if (fi < 23) begin op = 6'h11; fn = 7'(fi - 17); end
      else if (fi < 29) begin op = 6'h11; fn = 7'(fi - 23 + 16); end
      else              begin op = 6'h12; fn = 7'(fi - 29); end
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(mkr(op, 5'd1, 5'd2, fn, 5'd3), pat(i), pat(j), tag_of(mkr(op, 5'd1, 5'd2, fn, 5'd3)));
    end

    // R1: every literal value, register port carries a decoy
    for (int l = 0; l < 256; l++) begin
      run(mkl(6'h10, 5'd4, 8'(l), 7'h08, 5'd5), 64'h0000_0001_0000_0000, 64'hDEAD_BEEF_0000_0000, "R1");
      run(mkl(6'h12, 5'd4, 8'(l), 7'h01, 5'd5), 64'hF000_0000_0000_000F, 64'h0, "R1");
    end

    // R10: every shift amount, and register amounts above 63
    for (int s = 0; s < 128; s++) begin
      run(mkr(6'h12, 5'd6, 5'd7, 7'h00, 5'd8), 64'h1, 64'(s), "R10");
      run(mkr(6'h12, 5'd6, 5'd7, 7'h02, 5'd8), 64'h8000_0000_0000_0000, 64'(s), "R10");
      run(mkr(6'h12, 5'd6, 5'd7, 7'h01, 5'd8), 64'h8000_0000_0000_0001, 64'(s), "R10");
    end

    // R2: register 31 as either source reads zero
    run(mkr(6'h11, 5'd31, 5'd2, 7'h02, 5'd9), 64'hAAAA_AAAA_AAAA_AAAA, 64'h5, "R2");
    run(mkr(6'h11, 5'd1, 5'd31, 7'h02, 5'd9), 64'h5, 64'hAAAA_AAAA_AAAA_AAAA, "R2");
    run(mkr(6'h10, 5'd31, 5'd31, 7'h10, 5'd9), 64'h1, 64'h2, "R2");
    run(mkr(6'h11, 5'd31, 5'd2, 7'h10, 5'd9), 64'h7, 64'h1234, "R2");

    // R3: destination 31 never writes
    for (int i = 0; i < 8; i++)
      run(mkr(6'h10, 5'd1, 5'd2, 7'h08, 5'd31), pat(i), pat(7 - i), "R3");
    run(mkr(6'h11, 5'd1, 5'd2, 7'h11, 5'd31), 64'h5, 64'h6, "R3");

    // R11: unused opcodes and function codes
    for (int o = 0; o < 64; o++)
      if (o < 16 || o > 18)
        run(mkr(6'(o), 5'd1, 5'd2, 7'h00, 5'd3), 64'h1, 64'h1, "R11");
    for (int f = 0; f < 128; f++) begin
      if (f > 2) run(mkr(6'h12, 5'd1, 5'd2, 7'(f), 5'd3), 64'h1, 64'h1, "R11");
      if (!((f < 16 && (f & 6) != 6) || (f >= 16 && f <= 20)))
        run(mkr(6'h10, 5'd1, 5'd2, 7'(f), 5'd3), 64'h1, 64'h1, "R11");
      if (!(f <= 5 || (f >= 16 && f <= 21)))
        run(mkl(6'h11, 5'd1, 8'h3, 7'(f), 5'd3), 64'h1, 64'h1, "R11");
    end

    // R12: idle cycle after an illegal and after a write gives nothing
    run(mkr(6'h10, 5'd1, 5'd2, 7'h08, 5'd10), 64'h2, 64'h3, "R12");
    @(negedge clk); issue_valid = 1'b0; insn = mkr(6'h10, 5'd1, 5'd2, 7'h08, 5'd11);
    @(posedge clk); #1;
    nchk++;
    if (wr_en !== 1'b0 || illegal !== 1'b0) begin
      nerr++;
      $display("FAIL R12 idle: got we=%b ill=%b, exp we=0 ill=0", wr_en, illegal);
    end
    run(mkr(6'h3F, 5'd1, 5'd2, 7'h00, 5'd3), 64'h1, 64'h1, "R12");
    @(negedge clk); issue_valid = 1'b0;
    @(posedge clk); #1;
    nchk++;
    if (wr_en !== 1'b0 || illegal !== 1'b0) begin
      nerr++;
      $display("FAIL R12 idle after illegal: got we=%b ill=%b, exp we=0 ill=0", wr_en, illegal);
    end

    finish_run();
  end
endmodule